// File: doc/BRIEF.md
# Interrupt Status and Mask Unit

This block gathers single-cycle event pulses from a network controller's receive path, transmit path, statistics counters and host-bus logic, and holds each one in a status register until software acknowledges it. A mask register selects which held events may raise the single interrupt line. The same masked result is also shown as a summary bit in the status word, so software can poll it instead of taking the interrupt.

Software reaches the block through a plain register port. There is one address line: address 0 is the status word and address 1 is the mask. Reads are combinational and need no strobe. A write to the status word clears every held event whose data bit is one, and only the low fifteen bits can be cleared this way. Two level inputs, receive-idle and transmit-idle, appear above the summary bit without being latched.

A parameter chooses between two bit layouts for the host-bus error sources. In the wide layout three separate error events sit in bits 12 to 14. In the narrow layout one error event sits in bit 12 and a transceiver-event level sits in bit 15. There is no data stream here, so every pin is a plain control or status pin with no handshake.

Top module: `irq_status_unit`

## Requirements
- R1: While reset is active and in the first cycle after it, all held status bits, the mask and the interrupt output are zero.
- R2: A one on `ev_i[b]` for a latched bit sets status bit b from the next cycle on, and the bit stays set until it is cleared. Latched bits in both layouts: 0 receive done, 1 receive header, 2 receive full, 3 receive overflow, 4 receive error, 5 transmit done, 7 transmit empty, 8 transmit underrun, 9 counter full, 10 receive early warning, 11 receive started.
- R3: A write to address 0 clears, one cycle later, each held bit in positions 0 to 14 whose write-data bit is one. Data bits that are zero leave their status bits as they were.
- R4: An event pulse in the same cycle as a clear of the same bit leaves that bit set.
- R5: Status bit 16 is one exactly when some visible status bit in 15:0 is also set in the mask, and `irq_o` always equals it. The idle bits never contribute.
- R6: Status bits 17 and 18 show `rx_idle_i` and `tx_idle_i` in the same cycle, and writes do not change them.
- R7: A write to address 1 loads mask bits 15:0, which read back at address 1 with zeros above them. A zero mask keeps `irq_o` low whatever events are held.
- R8: With `WIDE_BUS_ERR`=1, bits 12, 13 and 14 are latched bus-error events and bit 15 reads zero. With `WIDE_BUS_ERR`=0, bit 12 is the only latched bus-error event, bits 13 and 14 read zero, and bit 15 follows `ev_i[15]` as a level that a write cannot clear.
- R9: Bit 6 and any position the layout leaves unused read zero whatever arrives on `ev_i`. Status bits 31:19 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_i | input | 16 | Event pulses, one per status position |
| rx_idle_i | input | 1 | Receive engine idle level |
| tx_idle_i | input | 1 | Transmit engine idle level |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 1 | 0 selects status, 1 selects mask |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | RD_W (32) | Read data for the selected register |
| irq_o | output | 1 | Interrupt request, equal to the summary bit |

## Verification
The bound checker checks on every cycle that an event sets its bit and wins over a clear in the same cycle, that a clear drops only the requested bits and that idle cycles hold the status. It also checks that the interrupt never rises without a masked source or with a zero mask, that the summary bit and the idle bits read back correctly, and that unused positions stay zero. Other behaviour needs the bench's scenarios and its reference model of both layouts, compared on every clock. These cover the mask readback, the exact sequence of sets and clears, the level behaviour of bit 15 in the narrow layout, the reset state, and long pseudo-random mixes of events and writes.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int unsigned EV_W    = 16;
  localparam int unsigned FLAG_W  = 3;   // summary, rx idle, tx idle
  localparam logic [EV_W-1:0] COMMON_EVENTS = 16'h0FBF;
  localparam logic [EV_W-1:0] CLEARABLE     = 16'h7FFF;

  function automatic logic [EV_W-1:0] latched_set(input bit wide);
    return wide ? (COMMON_EVENTS | 16'h7000) : (COMMON_EVENTS | 16'h1000);
  endfunction

  function automatic logic [EV_W-1:0] level_set(input bit wide);
    return wide ? 16'h0000 : 16'h8000;
  endfunction
endpackage

// File: rtl/irq_event_latch.sv
module irq_event_latch
  import irq_status_pkg::*;
#(
  parameter logic [EV_W-1:0] LATCH_BITS = 16'h7FBF,
  parameter logic [EV_W-1:0] LEVEL_BITS = 16'h0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev_i,
  input  logic [EV_W-1:0] clr_i,
  output logic [EV_W-1:0] stat_o
);
  localparam logic [EV_W-1:0] USED_BITS = LATCH_BITS | LEVEL_BITS;

  logic unused_ev;
  assign unused_ev = ^(ev_i & ~USED_BITS) ^ ^(clr_i & ~LATCH_BITS);

  for (genvar b = 0; b < EV_W; b++) begin : g_bit
    if (LATCH_BITS[b]) begin : g_latch
      logic held_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        held_q <= 1'b0;
        else if (ev_i[b])  held_q <= 1'b1;
        else if (clr_i[b]) held_q <= 1'b0;
      end
      assign stat_o[b] = held_q;
    end else if (LEVEL_BITS[b]) begin : g_level
      assign stat_o[b] = ev_i[b];
    end else begin : g_none
      assign stat_o[b] = 1'b0;
    end
  end
endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_status_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_i,
  input  logic [EV_W-1:0] data_i,
  output logic [EV_W-1:0] mask_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_o <= '0;
    else if (load_i) mask_o <= data_i;
  end
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_status_pkg::*;
(
  input  logic [EV_W-1:0] stat_i,
  input  logic [EV_W-1:0] mask_i,
  output logic            pending_o
);
  assign pending_o = |(stat_i & mask_i);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter bit          WIDE_BUS_ERR = 1'b1,
  parameter int unsigned RD_W         = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [EV_W-1:0] ev_i,
  input  logic            rx_idle_i,
  input  logic            tx_idle_i,
  input  logic            reg_wr_i,
  input  logic            reg_addr_i,
  input  logic [EV_W-1:0] reg_wdata_i,
  output logic [RD_W-1:0] reg_rdata_o,
  output logic            irq_o
);
  localparam logic [EV_W-1:0] LATCH_BITS = latched_set(WIDE_BUS_ERR);
  localparam logic [EV_W-1:0] LEVEL_BITS = level_set(WIDE_BUS_ERR);
  localparam int unsigned     PAD_W      = RD_W - EV_W - FLAG_W;

  logic [EV_W-1:0] clr_w, stat_w, mask_w;
  logic            pend_w, wr_stat, wr_mask;

  assign wr_stat = reg_wr_i && !reg_addr_i;
  assign wr_mask = reg_wr_i &&  reg_addr_i;
  assign clr_w   = wr_stat ? (reg_wdata_i & CLEARABLE) : '0;

  irq_event_latch #(.LATCH_BITS(LATCH_BITS), .LEVEL_BITS(LEVEL_BITS)) u_latch (
    .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .clr_i(clr_w), .stat_o(stat_w)
  );

  irq_mask_reg u_mask (
    .clk(clk), .rst_n(rst_n), .load_i(wr_mask), .data_i(reg_wdata_i), .mask_o(mask_w)
  );

  irq_summary u_sum (.stat_i(stat_w), .mask_i(mask_w), .pending_o(pend_w));

  assign irq_o = pend_w;

  always_comb begin
    if (reg_addr_i) reg_rdata_o = {{(RD_W-EV_W){1'b0}}, mask_w};
    else            reg_rdata_o = {{PAD_W{1'b0}}, tx_idle_i, rx_idle_i, pend_w, stat_w};
  end
endmodule

// File: rtl/irq_status_chk.sv
module irq_status_chk
  import irq_status_pkg::*;
#(
  parameter bit          WIDE_BUS_ERR = 1'b1,
  parameter int unsigned RD_W         = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic [EV_W-1:0] ev_i,
  input logic            rx_idle_i,
  input logic            tx_idle_i,
  input logic            wr,
  input logic            addr,
  input logic [EV_W-1:0] wdata,
  input logic [EV_W-1:0] stat,
  input logic [EV_W-1:0] mask,
  input logic [RD_W-1:0] rdata,
  input logic            irq
);
  localparam logic [EV_W-1:0] LAT = latched_set(WIDE_BUS_ERR);
  localparam logic [EV_W-1:0] LEV = level_set(WIDE_BUS_ERR);

  p_event_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((ev_i & LAT) != '0) |=> ((stat & $past(ev_i & LAT)) == $past(ev_i & LAT)));

  p_event_beats_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr && ((ev_i & wdata & LAT) != '0))
      |=> ((stat & $past(ev_i & wdata & LAT)) == $past(ev_i & wdata & LAT)));

  p_clear_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !addr) |=> ((stat & $past(wdata & CLEARABLE & LAT & ~ev_i)) == '0));

  p_quiet_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && !addr) && ((ev_i & LAT) == '0)) |=> ((stat & LAT) == $past(stat & LAT)));

  p_zero_mask_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '0) |-> !irq);

  p_irq_has_source_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> ((stat & mask) != '0));

  p_summary_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !addr |-> (rdata[16] == irq));

  p_idle_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !addr |-> (rdata[18:17] == {tx_idle_i, rx_idle_i}));

  p_unused_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((stat & ~(LAT | LEV)) == '0));
endmodule

bind irq_status_unit irq_status_chk #(.WIDE_BUS_ERR(WIDE_BUS_ERR), .RD_W(RD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ev_i(ev_i), .rx_idle_i(rx_idle_i), .tx_idle_i(tx_idle_i),
  .wr(reg_wr_i), .addr(reg_addr_i), .wdata(reg_wdata_i), .stat(stat_w), .mask(mask_w),
  .rdata(reg_rdata_o), .irq(irq_o)
);

// File: tb/tb_irq_status_unit.sv
`timescale 1ns/1ps
module tb_irq_status_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev = '0;
  logic        rx_idle = 1'b0, tx_idle = 1'b0;
  logic        wr = 1'b0, addr = 1'b0;
  logic [15:0] wdata = '0;
  logic [31:0] rd_w, rd_n;
  logic        irq_w, irq_n;

  int    n_chk = 0, n_bad = 0;
  string tag = "R1";
  bit    done = 1'b0;

  always #2.5 clk = ~clk;

  irq_status_unit #(.WIDE_BUS_ERR(1'b1)) dut (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .rx_idle_i(rx_idle), .tx_idle_i(tx_idle),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd_w), .irq_o(irq_w));

  irq_status_unit #(.WIDE_BUS_ERR(1'b0)) dut_alt (
    .clk(clk), .rst_n(rst_n), .ev_i(ev), .rx_idle_i(rx_idle), .tx_idle_i(tx_idle),
    .reg_wr_i(wr), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rd_n), .irq_o(irq_n));

  // Reference model, written from the requirements
  logic [15:0] st_w = '0, st_n = '0, mk_w = '0, mk_n = '0;
  localparam logic [15:0] LAT_WIDE = 16'h7FBF;
  localparam logic [15:0] LAT_NARR = 16'h1FBF;

  always @(posedge clk) begin
    logic [15:0] clr;
    if (!rst_n) begin
      st_w = '0; st_n = '0; mk_w = '0; mk_n = '0;
    end else begin
      clr  = (wr && !addr) ? (wdata & 16'h7FFF) : 16'h0;
      st_w = (st_w & ~clr) | (ev & LAT_WIDE);
      st_n = (st_n & ~clr) | (ev & LAT_NARR);
      if (wr && addr) begin mk_w = wdata; mk_n = wdata; end
    end
  end

  function automatic logic [32:0] expect_of(bit wide, logic [15:0] st, logic [15:0] mk);
    logic [15:0] vis;
    logic        pend;
    vis  = st | (wide ? 16'h0 : (ev & 16'h8000));
    pend = |(vis & mk);
    if (addr) return {pend, 16'h0, mk};
    return {pend, 13'h0, tx_idle, rx_idle, pend, vis};
  endfunction

  task automatic check(string which, logic [31:0] rd, logic irq, logic [32:0] e);
    n_chk++;
    if (rd !== e[31:0] || irq !== e[32]) begin
      n_bad++;
      $display("FAIL %s %s: rdata %h irq %b, expected rdata %h irq %b",
               tag, which, rd, irq, e[31:0], e[32]);
    end
  endtask

  always @(negedge clk) if (!done) begin
    check("wide", rd_w, irq_w, expect_of(1'b1, st_w, mk_w));
    check("narrow", rd_n, irq_n, expect_of(1'b0, st_n, mk_n));
  end

  task automatic drive(logic [15:0] e, logic w, logic a, logic [15:0] d);
    @(negedge clk); #1;
    ev = e; wr = w; addr = a; wdata = d;
  endtask

  task automatic quiet(int n, logic a);
    for (int i = 0; i < n; i++) drive(16'h0, 1'b0, a, 16'h0);
  endtask

  initial begin
    int lfsr;
    tag = "R1";
    quiet(3, 1'b0);
    quiet(1, 1'b1);
    #1 rst_n = 1'b1;
    quiet(1, 1'b0);
    quiet(1, 1'b1);

    tag = "R2";
    for (int b = 0; b < 16; b++) begin
      drive(16'h1 << b, 1'b0, 1'b0, 16'h0);
      quiet(1, 1'b0);
    end
    drive(16'h0, 1'b1, 1'b0, 16'hFFFF);
    quiet(2, 1'b0);

    tag = "R7";
    drive(16'h0, 1'b1, 1'b1, 16'hFFFF);
    quiet(1, 1'b1);
    drive(16'h0001, 1'b0, 1'b0, 16'h0);
    quiet(2, 1'b0);
    drive(16'h0, 1'b1, 1'b1, 16'h0000);
    drive(16'h0FFF, 1'b0, 1'b0, 16'h0);
    quiet(2, 1'b0);
    quiet(1, 1'b1);

    tag = "R3";
    drive(16'h0, 1'b1, 1'b0, 16'h0005);
    quiet(1, 1'b0);
    drive(16'h0, 1'b1, 1'b0, 16'h0000);
    quiet(1, 1'b0);
    drive(16'h0, 1'b1, 1'b0, 16'hFFFF);
    quiet(1, 1'b0);

    tag = "R4";
    drive(16'h0009, 1'b0, 1'b0, 16'h0);
    drive(16'h0001, 1'b1, 1'b0, 16'h0009);
    quiet(2, 1'b0);

    tag = "R6";
    rx_idle = 1'b1;
    quiet(1, 1'b0);
    tx_idle = 1'b1;
    drive(16'h0, 1'b1, 1'b0, 16'hFFFF);
    quiet(1, 1'b0);
    rx_idle = 1'b0;
    quiet(1, 1'b0);

    tag = "R5";
    drive(16'h0, 1'b1, 1'b1, 16'h0008);
    drive(16'h0FF7, 1'b0, 1'b0, 16'h0);
    quiet(1, 1'b0);
    drive(16'h0008, 1'b0, 1'b0, 16'h0);
    quiet(2, 1'b0);
    drive(16'h0, 1'b1, 1'b0, 16'h0008);
    quiet(2, 1'b0);
    tx_idle = 1'b0;

    tag = "R8";
    drive(16'h0, 1'b1, 1'b1, 16'hF000);
    drive(16'h2000, 1'b0, 1'b0, 16'h0);
    quiet(1, 1'b0);
    drive(16'h8000, 1'b0, 1'b0, 16'h0);
    drive(16'h8000, 1'b1, 1'b0, 16'hF000);
    drive(16'h8000, 1'b0, 1'b0, 16'h0);
    quiet(2, 1'b0);
    drive(16'h1000, 1'b0, 1'b0, 16'h0);
    quiet(1, 1'b0);
    drive(16'h0, 1'b1, 1'b0, 16'h7000);
    quiet(1, 1'b0);

    tag = "R9";
    drive(16'hFFFF, 1'b0, 1'b0, 16'h0);
    drive(16'h0040, 1'b0, 1'b0, 16'h0);
    quiet(1, 1'b0);
    drive(16'h0, 1'b1, 1'b0, 16'hFFFF);
    quiet(1, 1'b0);

    tag = "R5";
    lfsr = 32'h1ACE_B00C;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      rx_idle = lfsr[20];
      tx_idle = lfsr[9];
      drive(lfsr[15:0] & {lfsr[31:16] & lfsr[27:12]}, lfsr[18] & lfsr[5],
            lfsr[11], lfsr[29:14]);
    end
    quiet(3, 1'b0);

    @(negedge clk); #1 done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    done = 1'b1;
    n_bad++;
    $display("FAIL watchdog %s: run did not end, actual timeout expected completion", tag);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule